// File: doc/BRIEF.md
# DMA Interrupt Flag Register Bank

This block keeps the interrupt status flags for a five-channel DMA controller. Every channel owns four sticky flags: a summary ("any event") flag, a transfer-complete flag, a half-transfer flag and an error flag. The channel engines report their events as single-cycle pulses, and each pulse sets the matching flag together with the channel's summary flag. A flag stays set until software clears it.

Software sees the bank through a simple register bus. One offset returns the read-only status word. A second offset is a write-only clear register: each 1 bit written there clears one flag for a single cycle and leaves no stored state. When a channel's summary clear bit is written, all four of that channel's flags are cleared together. The bank also drives one interrupt line per channel. That line is the OR of the channel's three event flags, each gated by its own enable input.

Top module: `dma_irq_flag_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every flag is 0, both offsets read 0 and all interrupt lines are low.
- R2: Channel c (0..4) uses status bits 4c..4c+3: bit 4c is the summary flag, 4c+1 transfer complete, 4c+2 half transfer and 4c+3 error. Status bits 31:20 always read 0.
- R3: An event pulse in one cycle sets its own flag and the channel's summary flag, both visible on the next cycle. Flags then stay set.
- R4: A write to the status offset (0x00) changes no flag.
- R5: Writing 1 to clear-register bit 4c (offset 0x04) clears all four flags of channel c and leaves every other channel unchanged.
- R6: Writing 1 to clear-register bit 4c+1, 4c+2 or 4c+3 clears only the transfer-complete, half-transfer or error flag of channel c. The summary flag is not touched.
- R7: Zero bits in a clear-register write have no effect, so a clear write of all zeros changes nothing.
- R8: When an event and a clear of the same flag fall in the same cycle, the flag ends up set. This includes the summary flag when a summary clear collides with any event on that channel.
- R9: The clear offset always reads 0, and so does any offset that is not mapped.
- R10: irq[c] = (tc & ie_tc[c]) | (ht & ie_ht[c]) | (err & ie_err[c]) for channel c. The line follows enable changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and flag clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_tc | input | 5 | Transfer-complete event pulse, one bit per channel |
| evt_ht | input | 5 | Half-transfer event pulse, one bit per channel |
| evt_err | input | 5 | Error event pulse, one bit per channel |
| ie_tc | input | 5 | Transfer-complete interrupt enable, per channel |
| ie_ht | input | 5 | Half-transfer interrupt enable, per channel |
| ie_err | input | 5 | Error interrupt enable, per channel |
| irq | output | 5 | Interrupt request, one per channel |

## Verification
A hardware event and a software clear of the same flag can fall in the same cycle. The bench provokes this by driving a transfer-complete pulse alongside a write of that channel's transfer-complete clear bit. It also drives a half-transfer pulse alongside a summary clear of the same channel. The scoreboard expects the colliding flags and the summary flag to read back set, and the uncontested flags of that channel to read back cleared.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;

   localparam int FLAGS_PER_CH = 4;

   localparam int FLG_GLB = 0;
   localparam int FLG_TC  = 1;
   localparam int FLG_HT  = 2;
   localparam int FLG_ERR = 3;

   typedef struct packed {
      logic err;
      logic ht;
      logic tc;
      logic glb;
   } chan_flags_t;

   typedef struct packed {
      logic err;
      logic ht;
      logic tc;
   } chan_evt_t;

endpackage

// File: rtl/dma_flag_chan.sv
module dma_flag_chan
   import dma_flag_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  chan_evt_t   evt,
   input  chan_flags_t clr,
   output chan_flags_t flags
);

   chan_flags_t set_v;
   chan_flags_t clr_v;
   chan_flags_t nxt;

   always_comb begin
      set_v.glb = evt.tc | evt.ht | evt.err;
      set_v.tc  = evt.tc;
      set_v.ht  = evt.ht;
      set_v.err = evt.err;
      clr_v.glb = clr.glb;
      clr_v.tc  = clr.glb | clr.tc;
      clr_v.ht  = clr.glb | clr.ht;
      clr_v.err = clr.glb | clr.err;
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb nxt = set_v | (flags & ~clr_v);
      end else begin : g_clr_wins
         always_comb nxt = (flags | set_v) & ~clr_v;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= nxt;
   end

endmodule

// File: rtl/dma_flag_bus_dec.sv
module dma_flag_bus_dec #(
   parameter int NUM_CH   = 5,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int STAT_OFS = 0,
   parameter int CLR_OFS  = 4
) (
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic [4*NUM_CH-1:0]   status,
   output logic [4*NUM_CH-1:0]   clr_pulse,
   output logic [DATA_W-1:0]     bus_rdata
);

   localparam int STAT_W = 4 * NUM_CH;
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

   initial begin
      if (STAT_OFS == CLR_OFS)
         $error("dma_flag_bus_dec: status and clear offsets coincide");
      if ((STAT_OFS % 4) != 0 || (CLR_OFS % 4) != 0)
         $error("dma_flag_bus_dec: offsets must be word aligned");
   end

   logic hit_clr;
   logic hit_stat;

   assign hit_clr  = (bus_addr == CLR_A);
   assign hit_stat = (bus_addr == STAT_A);

   always_comb begin
      clr_pulse = '0;
      if (bus_wr && hit_clr) clr_pulse = bus_wdata[STAT_W-1:0];
   end

   generate
      if (DATA_W > STAT_W) begin : g_pad
         always_comb begin
            bus_rdata = '0;
            if (hit_stat) bus_rdata = {{(DATA_W-STAT_W){1'b0}}, status};
         end
      end else begin : g_nopad
         always_comb begin
            bus_rdata = '0;
            if (hit_stat) bus_rdata = status;
         end
      end
   endgenerate

endmodule

// File: rtl/dma_flag_irq.sv
module dma_flag_irq
   import dma_flag_pkg::*;
#(
   parameter int NUM_CH = 5
) (
   input  logic [4*NUM_CH-1:0] status,
   input  logic [NUM_CH-1:0]   ie_tc,
   input  logic [NUM_CH-1:0]   ie_ht,
   input  logic [NUM_CH-1:0]   ie_err,
   output logic [NUM_CH-1:0]   irq
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_flags_t f;
      assign f = status[4*c +: 4];
      assign irq[c] = (f.tc & ie_tc[c]) | (f.ht & ie_ht[c]) | (f.err & ie_err[c]);
   end

endmodule

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank
   import dma_flag_pkg::*;
#(
   parameter int NUM_CH   = 5,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int STAT_OFS = 0,
   parameter int CLR_OFS  = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] evt_tc,
   input  logic [NUM_CH-1:0] evt_ht,
   input  logic [NUM_CH-1:0] evt_err,
   input  logic [NUM_CH-1:0] ie_tc,
   input  logic [NUM_CH-1:0] ie_ht,
   input  logic [NUM_CH-1:0] ie_err,
   output logic [NUM_CH-1:0] irq
);

   localparam int STAT_W = FLAGS_PER_CH * NUM_CH;

   initial begin
      if (NUM_CH < 1) $error("dma_irq_flag_bank: NUM_CH must be at least 1");
      if (DATA_W < STAT_W) $error("dma_irq_flag_bank: DATA_W too small for status");
      if ((1 << ADDR_W) <= CLR_OFS || (1 << ADDR_W) <= STAT_OFS)
         $error("dma_irq_flag_bank: offsets do not fit ADDR_W");
   end

   logic [STAT_W-1:0] flag_q;
   logic [STAT_W-1:0] clr_pulse;

   dma_flag_bus_dec #(
      .NUM_CH  (NUM_CH),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .STAT_OFS(STAT_OFS),
      .CLR_OFS (CLR_OFS)
   ) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .status   (flag_q),
      .clr_pulse(clr_pulse),
      .bus_rdata(bus_rdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_evt_t   ev;
      chan_flags_t cl;
      chan_flags_t fl;
      assign ev.tc  = evt_tc[c];
      assign ev.ht  = evt_ht[c];
      assign ev.err = evt_err[c];
      assign cl     = clr_pulse[FLAGS_PER_CH*c +: FLAGS_PER_CH];
      dma_flag_chan #(.SET_WINS(SET_WINS)) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .evt  (ev),
         .clr  (cl),
         .flags(fl)
      );
      assign flag_q[FLAGS_PER_CH*c +: FLAGS_PER_CH] = fl;
   end

   dma_flag_irq #(.NUM_CH(NUM_CH)) u_irq (
      .status(flag_q),
      .ie_tc (ie_tc),
      .ie_ht (ie_ht),
      .ie_err(ie_err),
      .irq   (irq)
   );

endmodule

// File: rtl/dma_irq_flag_bank_chk.sv
module dma_irq_flag_bank_chk #(
   parameter int NUM_CH   = 5,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CLR_OFS  = 4,
   parameter bit SET_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NUM_CH-1:0] evt_tc,
   input logic [NUM_CH-1:0] evt_ht,
   input logic [NUM_CH-1:0] evt_err,
   input logic [NUM_CH-1:0] ie_tc,
   input logic [NUM_CH-1:0] ie_ht,
   input logic [NUM_CH-1:0] ie_err,
   input logic [NUM_CH-1:0] irq,
   input logic [4*NUM_CH-1:0] flag_q
);

   localparam int SW = 4 * NUM_CH;

   logic clr_wr;
   logic any_clr;
   logic any_evt;
   assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(CLR_OFS));
   assign any_clr = clr_wr && (|bus_wdata[SW-1:0]);
   assign any_evt = |{evt_tc, evt_ht, evt_err};

   // R1: reset leaves every flag cleared
   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flag_q == '0);

   // R4 and R7: without events or a nonzero clear write, nothing moves
   a_r4_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_evt && !any_clr) |=> $stable(flag_q));

   // R9: the clear offset reads zero
   a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CLR_OFS)) |-> bus_rdata == '0);

   generate
      if (DATA_W > SW) begin : g_pad
         // R2: reserved upper bits read zero
         a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:SW] == '0);
      end
   endgenerate

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ch_evt;
      assign ch_evt = evt_tc[c] | evt_ht[c] | evt_err[c];

      if (SET_WINS) begin : g_sw
         // R3 and R8: an event always lands, even against a clear
         a_r3_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_tc[c] |=> flag_q[4*c+1] && flag_q[4*c]);
         a_r3_ht_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_ht[c] |=> flag_q[4*c+2] && flag_q[4*c]);
         a_r8_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_err[c] |=> flag_q[4*c+3] && flag_q[4*c]);
      end

      // R5: summary clear wipes the channel group
      a_r5_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && bus_wdata[4*c] && !ch_evt) |=> flag_q[4*c +: 4] == 4'b0000);

      // R6: individual clear leaves the summary flag alone
      a_r6_tc_only: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && bus_wdata[4*c+1] && !bus_wdata[4*c] && !ch_evt)
            |=> !flag_q[4*c+1] && (flag_q[4*c] == $past(flag_q[4*c])));

      // R10: interrupt line tracks enabled flags
      a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] == ((flag_q[4*c+1] & ie_tc[c]) | (flag_q[4*c+2] & ie_ht[c])
                   | (flag_q[4*c+3] & ie_err[c])));
   end

endmodule

bind dma_irq_flag_bank dma_irq_flag_bank_chk #(
   .NUM_CH  (NUM_CH),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CLR_OFS (CLR_OFS),
   .SET_WINS(SET_WINS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .evt_tc   (evt_tc),
   .evt_ht   (evt_ht),
   .evt_err  (evt_err),
   .ie_tc    (ie_tc),
   .ie_ht    (ie_ht),
   .ie_err   (ie_err),
   .irq      (irq),
   .flag_q   (flag_q)
);

// File: tb/dma_irq_flag_bank_bench.sv
module dma_irq_flag_bank_bench;

   localparam int N = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] evt_tc = '0, evt_ht = '0, evt_err = '0;
   logic [N-1:0] ie_tc = '0, ie_ht = '0, ie_err = '0;
   logic [N-1:0] irq;

   always #4 clk = ~clk;

   dma_irq_flag_bank u_dma_irq_flag_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_tc(evt_tc),
      .evt_ht(evt_ht), .evt_err(evt_err), .ie_tc(ie_tc), .ie_ht(ie_ht),
      .ie_err(ie_err), .irq(irq)
   );

   typedef struct {
      string       req;
      logic [31:0] exp_rd;
      logic [N-1:0] exp_irq;
   } item_t;

   item_t q[$];
   event  sample_ev;
   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   logic [19:0] model = '0;

   // monitor: compares design results against queued expectations
   initial begin
      forever begin
         @(sample_ev);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (bus_rdata !== it.exp_rd) begin
               bad++;
               $display("FAIL %s rdata actual=%h expected=%h", it.req, bus_rdata, it.exp_rd);
            end
            total++;
            if (irq !== it.exp_irq) begin
               bad++;
               $display("FAIL %s irq actual=%b expected=%b", it.req, irq, it.exp_irq);
            end
         end
      end
   end

   function automatic logic [N-1:0] model_irq();
      logic [N-1:0] r;
      for (int c = 0; c < N; c++)
         r[c] = (model[4*c+1] & ie_tc[c]) | (model[4*c+2] & ie_ht[c]) | (model[4*c+3] & ie_err[c]);
      return r;
   endfunction

   // one bus/event cycle, then update the expectation model
   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [N-1:0] etc, input logic [N-1:0] eht, input logic [N-1:0] eer);
      logic [19:0] clr;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      evt_tc = etc; evt_ht = eht; evt_err = eer;
      @(posedge clk);
      clr = (wr && a == 8'h04) ? d[19:0] : '0;
      for (int c = 0; c < N; c++) begin
         logic g;
         g = clr[4*c];
         if (g) model[4*c +: 4] = 4'b0000;
         for (int b = 1; b < 4; b++)
            if (clr[4*c+b]) model[4*c+b] = 1'b0;
         if (etc[c]) model[4*c+1] = 1'b1;
         if (eht[c]) model[4*c+2] = 1'b1;
         if (eer[c]) model[4*c+3] = 1'b1;
         if (etc[c] | eht[c] | eer[c]) model[4*c] = 1'b1;
      end
   endtask

   // idle cycle with a read; expected values pushed to the scoreboard
   task automatic look(input logic [7:0] a, input string req);
      item_t it;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; evt_tc = '0; evt_ht = '0; evt_err = '0;
      bus_addr = a;
      #1;
      it.req = req;
      it.exp_rd = (a == 8'h00) ? {12'h000, model} : 32'h0;
      it.exp_irq = model_irq();
      q.push_back(it);
      ->sample_ev;
      #1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      ie_tc = '1; ie_ht = '1; ie_err = '1;
      look(8'h00, "R1 status in reset");
      look(8'h04, "R1 clear offset in reset");
      @(negedge clk); rst_n = 1'b1;
      look(8'h00, "R1 status after reset");

      // R3 / R2: events set their flag plus summary in the documented positions
      step(1'b0, 8'h00, 0, 5'b00001, 5'b00000, 5'b00000);
      look(8'h00, "R3 tc ch0 sets bits 0,1");
      step(1'b0, 8'h00, 0, 5'b00000, 5'b00100, 5'b10000);
      look(8'h00, "R3 ht ch2 err ch4");
      look(8'h00, "R3 flags persist");

      // R4: write to status offset ignored
      step(1'b1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
      look(8'h00, "R4 status write ignored");
      // R7: zero clear write ignored
      step(1'b1, 8'h04, 32'h0, 0, 0, 0);
      look(8'h00, "R7 zero clear ignored");
      // R9: clear and unmapped offsets read zero
      look(8'h04, "R9 clear offset reads zero");
      look(8'h10, "R9 unmapped offset reads zero");

      // R6: individual clears, summary untouched
      step(1'b1, 8'h04, 32'h0000_0002, 0, 0, 0);
      look(8'h00, "R6 tc clear ch0");
      step(1'b1, 8'h04, 32'h0008_0400, 0, 0, 0);
      look(8'h00, "R6 ht clear ch2 err clear ch4");

      // R5: summary clear wipes only its channel
      step(1'b0, 8'h00, 0, 5'b00100, 5'b00000, 5'b01000);
      step(1'b1, 8'h04, 32'h0000_0100, 0, 0, 0);
      look(8'h00, "R5 group clear ch2 only");

      // R8: event and clear in the same cycle, set wins
      step(1'b1, 8'h04, 32'h0000_0020, 5'b00010, 0, 0);
      look(8'h00, "R8 tc set beats tc clear ch1");
      step(1'b0, 8'h00, 0, 0, 0, 5'b00010);
      step(1'b1, 8'h04, 32'h0000_0010, 0, 5'b00010, 0);
      look(8'h00, "R8 ht set beats summary clear ch1");

      // R2: all flags set, upper bits zero
      step(1'b0, 8'h00, 0, 5'b11111, 5'b11111, 5'b11111);
      look(8'h00, "R2 full status layout");

      // R10: enable gating
      ie_tc = 5'b00001; ie_ht = 5'b00100; ie_err = 5'b10000;
      look(8'h00, "R10 partial enables");
      step(1'b1, 8'h04, 32'h000F_FFFF, 0, 0, 0);
      step(1'b0, 8'h00, 0, 0, 5'b00011, 0);
      ie_tc = '1; ie_ht = 5'b00001; ie_err = '1;
      look(8'h00, "R10 ht enabled only ch0");
      ie_ht = '0;
      look(8'h00, "R10 all ht disabled");

      done = 1;
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule